// File: doc/BRIEF.md
# PRBS Receive Monitor

This block watches a received serial bit stream for a pseudo-random binary sequence. Only the bit positions picked by a per-slot enable mask and the 56 kbit/s channel mode are examined. The checker is self-synchronising: each examined bit is shifted into a history register, and the polynomial taps of that register predict the next bit. After a full register length of agreeing predictions, the block locks onto either the true or the inverted sequence. Each later disagreement produces one error strobe, which can feed an external bit error counter.

A separate run-length detector notices a line stuck at one level. When it does, it reports a dedicated status code and raises the interrupt on every examined bit for as long as the condition lasts. To tell a stuck-low line from a stuck-high one, the block recalls which polarity it first locked to after being enabled. An all-zero stream looks like the true sequence to the checker, and an all-one stream looks like the inverted one. An alarm-simulation input forces the status to "no pattern" without disturbing the lock state.

Top module: `prbs_rx_monitor`

## Requirements
- R1: After reset, and in every cycle after one in which `mon_en` is low, `pat_status` is 00 and `status_irq`, `bit_err_stb` and `flat_is_ones` are 0. Disabling clears all lock, history and run state, so the next enable starts afresh.
- R2: `poly_sel` values 0, 1, 2 and 3 select register lengths N = 11, 15, 20 and 23, with tap pairs (11,9), (15,14), (20,3) and (23,18). A bit is predicted as b[n-a] XOR b[n-b]. On a true sequence, `pat_status` becomes 01 in the output for the 2N-th examined bit after enable: N bits fill the register, then N consecutive agreeing bits follow.
- R3: On an inverted sequence, every examined bit is the complement of its prediction. `pat_status` becomes 10 with the same timing as R2.
- R4: After L consecutive equal examined bits, `pat_status` is 11, with L = 12, 16, 21 or 24 for `poly_sel` 0 to 3. At L-1 such bits it is not yet 11. Code 11 takes priority over the lock codes.
- R5: While locked, if more than ERR_LIMIT (default 8) errors fall within one window of WIN (default 64) examined bits, the lock is dropped and `pat_status` returns to 00.
- R6: `status_irq` pulses for one cycle on every change of `pat_status` while enabled. While the status is 11, it is also high after every examined bit.
- R7: While locked, `bit_err_stb` is high for one cycle for each examined bit that disagrees with its prediction under the locked polarity. Because the checker feeds on the received bits, one flipped bit gives strobes at its own position and again b and a examined bits later.
- R8: A bit is examined only if `rx_valid` is high, `slot_en[rx_slot]` is 1, and it is not the case that `mode_56k` is high and `rx_bitpos` is 7. Other bits neither produce errors nor enter the history or run state.
- R9: While `alarm_sim` is high, `pat_status` is 00. The lock state is kept, so the previous code returns when the alarm clears.
- R10: While `pat_status` is 11, `flat_is_ones` equals the polarity of the first lock reached since enable (1 = inverted, meaning all ones). Otherwise it is 0.
- R11: Every output is registered and shows the effect of an input one clock edge after that input is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mon_en | input | 1 | Monitor enable; low clears the state |
| alarm_sim | input | 1 | Forces the status to no pattern |
| poly_sel | input | 2 | Polynomial select (0: 2^11-1, 1: 2^15-1, 2: 2^20-1, 3: 2^23-1) |
| slot_en | input | NSLOT | Per-slot enable mask |
| mode_56k | input | 1 | When high, bit position 7 of each slot is skipped |
| rx_valid | input | 1 | A received bit is present this cycle |
| rx_slot | input | SLOT_W | Slot index of the bit |
| rx_bitpos | input | 3 | Bit position inside the slot |
| rx_bit | input | 1 | Received data bit |
| pat_status | output | 2 | 00 none, 01 PRBS, 10 inverted PRBS, 11 all zeros or all ones |
| flat_is_ones | output | 1 | With status 11: 1 means all ones, 0 means all zeros |
| bit_err_stb | output | 1 | One-cycle strobe per bit error |
| status_irq | output | 1 | Interrupt pulse |

## Verification
Every result for a bit (status code, error strobe, interrupt, ones flag) is due one edge after the bit is sampled. The bench pushes one expectation per driven cycle and compares it at the next falling edge, so each comparison lands in exactly that cycle. Expected lock points (2N bits), run points (L bits) and the triple error strobes of a single flipped bit are counted in examined bits from the taps in the requirements. Gated bits are interleaved with the live sequence, and the bench shows that no error follows them.

// File: rtl/prbs_mon_pkg.sv
package prbs_mon_pkg;

   localparam int REG_MAX = 23;
   localparam int RUN_MAX = 24;

   typedef enum logic [1:0] {
      PM_NONE = 2'b00,
      PM_TRUE = 2'b01,
      PM_INV  = 2'b10,
      PM_FLAT = 2'b11
   } pm_status_e;

   // longest tap (register length) for each polynomial select
   function automatic logic [4:0] pm_tap_hi(input logic [1:0] s);
      case (s)
         2'd0:    return 5'd11;
         2'd1:    return 5'd15;
         2'd2:    return 5'd20;
         default: return 5'd23;
      endcase
   endfunction

   function automatic logic [4:0] pm_tap_lo(input logic [1:0] s);
      case (s)
         2'd0:    return 5'd9;
         2'd1:    return 5'd14;
         2'd2:    return 5'd3;
         default: return 5'd18;
      endcase
   endfunction

   // equal-bit run length that flags a stuck line
   function automatic logic [4:0] pm_run_len(input logic [1:0] s);
      case (s)
         2'd0:    return 5'd12;
         2'd1:    return 5'd16;
         2'd2:    return 5'd21;
         default: return 5'd24;
      endcase
   endfunction

endpackage

// File: rtl/prbs_mon_gate.sv
module prbs_mon_gate #(
   parameter int NSLOT   = 24,
   parameter int SLOT_W  = $clog2(NSLOT),
   parameter bit HAS_56K = 1'b1
) (
   input  logic              rx_valid,
   input  logic [SLOT_W-1:0] rx_slot,
   input  logic [2:0]        rx_bitpos,
   input  logic [NSLOT-1:0]  slot_en,
   input  logic              mode_56k,
   output logic              qual
);

   logic slot_ok;
   logic skip_bit;

   always_comb begin
      slot_ok = 1'b0;
      for (int i = 0; i < NSLOT; i++) begin
         if (rx_slot == SLOT_W'(i)) slot_ok = slot_en[i];
      end
   end

   generate
      if (HAS_56K) begin : g_56k
         assign skip_bit = mode_56k && (rx_bitpos == 3'd7);
      end else begin : g_64k
         logic unused_56k;
         assign unused_56k = ^{mode_56k, rx_bitpos};
         assign skip_bit   = 1'b0;
      end
   endgenerate

   assign qual = rx_valid && slot_ok && !skip_bit;

   initial begin
      assert (NSLOT >= 1 && SLOT_W >= $clog2(NSLOT))
         else $error("prbs_mon_gate: slot index too narrow");
   end

endmodule

// File: rtl/prbs_mon_chk.sv
module prbs_mon_chk
   import prbs_mon_pkg::*;
#(
   parameter int REG_W = REG_MAX
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       clr,
   input  logic       qual,
   input  logic       rx_bit,
   input  logic [1:0] sel,
   output logic       pred,
   output logic       fill_done
);

   localparam int IW = $clog2(REG_W);

   logic [REG_W-1:0] hist_q;
   logic [4:0]       fill_q;
   logic [4:0]       hi, lo;

   assign hi   = pm_tap_hi(sel);
   assign lo   = pm_tap_lo(sel);
   assign pred = hist_q[IW'(hi - 5'd1)] ^ hist_q[IW'(lo - 5'd1)];
   assign fill_done = (fill_q >= hi);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hist_q <= '0;
         fill_q <= '0;
      end else if (clr) begin
         hist_q <= '0;
         fill_q <= '0;
      end else if (qual) begin
         hist_q <= {hist_q[REG_W-2:0], rx_bit};
         if (fill_q < hi) fill_q <= fill_q + 5'd1;
      end
   end

   initial begin
      assert (REG_W >= REG_MAX && REG_W <= 32)
         else $error("prbs_mon_chk: history must hold the longest polynomial");
   end

endmodule

// File: rtl/prbs_mon_sync.sv
module prbs_mon_sync
   import prbs_mon_pkg::*;
#(
   parameter int WIN       = 64,
   parameter int ERR_LIMIT = 8
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       clr,
   input  logic       qual,
   input  logic       rx_bit,
   input  logic       pred,
   input  logic       fill_done,
   input  logic [1:0] sel,
   output logic       locked_d,
   output logic       linv_d,
   output logic       first_inv_d,
   output logic       err_hit
);

   localparam int WW = $clog2(WIN);
   localparam int EW = $clog2(ERR_LIMIT + 2);
   localparam logic [WW-1:0] WIN_LAST = WW'(WIN - 1);
   localparam logic [EW-1:0] ERR_LIM  = EW'(ERR_LIMIT);

   logic          locked_q, linv_q, cand_q, cand_d;
   logic          first_seen_q, first_seen_d, first_inv_q;
   logic [4:0]    mcnt_q, mcnt_d;
   logic [WW-1:0] win_q, win_d;
   logic [EW-1:0] errs_q, errs_d, errs_sum;
   logic          mi;

   // mi = 1 when the bit is the complement of its prediction
   assign mi       = rx_bit ^ pred;
   assign errs_sum = errs_q + {{(EW-1){1'b0}}, err_hit};

   always_comb begin
      locked_d     = locked_q;
      linv_d       = linv_q;
      cand_d       = cand_q;
      mcnt_d       = mcnt_q;
      first_seen_d = first_seen_q;
      first_inv_d  = first_inv_q;
      win_d        = win_q;
      errs_d       = errs_q;
      err_hit      = 1'b0;
      if (clr) begin
         locked_d     = 1'b0;
         linv_d       = 1'b0;
         cand_d       = 1'b0;
         mcnt_d       = '0;
         first_seen_d = 1'b0;
         first_inv_d  = 1'b0;
         win_d        = '0;
         errs_d       = '0;
      end else if (qual) begin
         if (!locked_q) begin
            if (fill_done) begin
               if (mcnt_q != 5'd0 && mi == cand_q) begin
                  mcnt_d = mcnt_q + 5'd1;
               end else begin
                  mcnt_d = 5'd1;
                  cand_d = mi;
               end
               if (mcnt_d >= pm_tap_hi(sel)) begin
                  locked_d = 1'b1;
                  linv_d   = mi;
                  mcnt_d   = '0;
                  win_d    = '0;
                  errs_d   = '0;
                  if (!first_seen_q) begin
                     first_seen_d = 1'b1;
                     first_inv_d  = mi;
                  end
               end
            end
         end else begin
            err_hit = (mi != linv_q);
            if (errs_sum > ERR_LIM) begin
               locked_d = 1'b0;
               mcnt_d   = '0;
               win_d    = '0;
               errs_d   = '0;
            end else if (win_q == WIN_LAST) begin
               win_d  = '0;
               errs_d = '0;
            end else begin
               win_d  = win_q + WW'(1);
               errs_d = errs_sum;
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         locked_q     <= 1'b0;
         linv_q       <= 1'b0;
         cand_q       <= 1'b0;
         mcnt_q       <= '0;
         first_seen_q <= 1'b0;
         first_inv_q  <= 1'b0;
         win_q        <= '0;
         errs_q       <= '0;
      end else begin
         locked_q     <= locked_d;
         linv_q       <= linv_d;
         cand_q       <= cand_d;
         mcnt_q       <= mcnt_d;
         first_seen_q <= first_seen_d;
         first_inv_q  <= first_inv_d;
         win_q        <= win_d;
         errs_q       <= errs_d;
      end
   end

   AST_WIN_ERR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      errs_q <= ERR_LIM); // R5

   initial begin
      assert (WIN >= 4 && ERR_LIMIT >= 1 && ERR_LIMIT < WIN)
         else $error("prbs_mon_sync: window must exceed the error limit");
   end

endmodule

// File: rtl/prbs_mon_run.sv
module prbs_mon_run
   import prbs_mon_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       clr,
   input  logic       qual,
   input  logic       rx_bit,
   input  logic [1:0] sel,
   output logic       flat_d
);

   localparam logic [4:0] RUN_CAP = 5'(RUN_MAX);

   logic [4:0] cnt_q, cnt_d;
   logic       val_q, val_d;

   always_comb begin
      cnt_d = cnt_q;
      val_d = val_q;
      if (clr) begin
         cnt_d = '0;
         val_d = 1'b0;
      end else if (qual) begin
         if (cnt_q != 5'd0 && rx_bit == val_q) begin
            if (cnt_q != RUN_CAP) cnt_d = cnt_q + 5'd1;
         end else begin
            cnt_d = 5'd1;
            val_d = rx_bit;
         end
      end
   end

   assign flat_d = (cnt_d >= pm_run_len(sel));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         val_q <= 1'b0;
      end else begin
         cnt_q <= cnt_d;
         val_q <= val_d;
      end
   end

   AST_RUN_CAPPED: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= RUN_CAP); // R4

endmodule

// File: rtl/prbs_rx_monitor.sv
module prbs_rx_monitor
   import prbs_mon_pkg::*;
#(
   parameter int NSLOT     = 24,
   parameter int SLOT_W    = $clog2(NSLOT),
   parameter bit HAS_56K   = 1'b1,
   parameter int WIN       = 64,
   parameter int ERR_LIMIT = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mon_en,
   input  logic              alarm_sim,
   input  logic [1:0]        poly_sel,
   input  logic [NSLOT-1:0]  slot_en,
   input  logic              mode_56k,
   input  logic              rx_valid,
   input  logic [SLOT_W-1:0] rx_slot,
   input  logic [2:0]        rx_bitpos,
   input  logic              rx_bit,
   output logic [1:0]        pat_status,
   output logic              flat_is_ones,
   output logic              bit_err_stb,
   output logic              status_irq
);

   logic       qual, clr, pred, fill_done;
   logic       locked_d, linv_d, first_inv_d, err_hit, flat_d;
   pm_status_e st_q, st_d;
   logic       ones_q, irq_q, err_q;

   assign clr = !mon_en;

   prbs_mon_gate #(.NSLOT(NSLOT), .SLOT_W(SLOT_W), .HAS_56K(HAS_56K)) u_gate (
      .rx_valid (rx_valid),
      .rx_slot  (rx_slot),
      .rx_bitpos(rx_bitpos),
      .slot_en  (slot_en),
      .mode_56k (mode_56k),
      .qual     (qual)
   );

   prbs_mon_chk #(.REG_W(REG_MAX)) u_chk (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (clr),
      .qual     (qual),
      .rx_bit   (rx_bit),
      .sel      (poly_sel),
      .pred     (pred),
      .fill_done(fill_done)
   );

   prbs_mon_sync #(.WIN(WIN), .ERR_LIMIT(ERR_LIMIT)) u_sync (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr        (clr),
      .qual       (qual),
      .rx_bit     (rx_bit),
      .pred       (pred),
      .fill_done  (fill_done),
      .sel        (poly_sel),
      .locked_d   (locked_d),
      .linv_d     (linv_d),
      .first_inv_d(first_inv_d),
      .err_hit    (err_hit)
   );

   prbs_mon_run u_run (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (clr),
      .qual  (qual),
      .rx_bit(rx_bit),
      .sel   (poly_sel),
      .flat_d(flat_d)
   );

   always_comb begin
      if (!mon_en || alarm_sim) st_d = PM_NONE;
      else if (flat_d)          st_d = PM_FLAT;
      else if (locked_d)        st_d = linv_d ? PM_INV : PM_TRUE;
      else                      st_d = PM_NONE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= PM_NONE;
         ones_q <= 1'b0;
         irq_q  <= 1'b0;
         err_q  <= 1'b0;
      end else begin
         st_q   <= st_d;
         ones_q <= (st_d == PM_FLAT) && first_inv_d;
         irq_q  <= mon_en && ((st_d != st_q) || (st_d == PM_FLAT && qual));
         err_q  <= mon_en && err_hit;
      end
   end

   assign pat_status   = st_q;
   assign flat_is_ones = ones_q;
   assign status_irq   = irq_q;
   assign bit_err_stb  = err_q;

   AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !mon_en |=> (pat_status == 2'b00 && !status_irq && !bit_err_stb)); // R1

   AST_ALARM_FORCES_NONE: assert property (@(posedge clk) disable iff (!rst_n)
      alarm_sim |=> pat_status == 2'b00); // R9

   AST_IRQ_ON_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (pat_status != $past(pat_status)) && $past(mon_en) |-> status_irq); // R6

   AST_FLAT_IRQ_REPEATS: assert property (@(posedge clk) disable iff (!rst_n)
      (pat_status == 2'b11) && $past(qual) |-> status_irq); // R6

   AST_ERR_NEEDS_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
      !qual |=> !bit_err_stb); // R8

endmodule

// File: tb/prbs_rx_monitor_tb_top.sv
module prbs_rx_monitor_tb_top;

   localparam int NSLOT  = 24;
   localparam int SLOT_W = $clog2(NSLOT);

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              mon_en = 1'b0, alarm_sim = 1'b0, mode_56k = 1'b0;
   logic [1:0]        poly_sel = 2'd0;
   logic [NSLOT-1:0]  slot_en = ~(NSLOT'(1) << 5);
   logic              rx_valid = 1'b0, rx_bit = 1'b0;
   logic [SLOT_W-1:0] rx_slot = '0;
   logic [2:0]        rx_bitpos = 3'd0;
   logic [1:0]        pat_status;
   logic              flat_is_ones, bit_err_stb, status_irq;

   always #10 clk = ~clk;

   prbs_rx_monitor dut_i (
      .clk(clk), .rst_n(rst_n), .mon_en(mon_en), .alarm_sim(alarm_sim),
      .poly_sel(poly_sel), .slot_en(slot_en), .mode_56k(mode_56k),
      .rx_valid(rx_valid), .rx_slot(rx_slot), .rx_bitpos(rx_bitpos),
      .rx_bit(rx_bit), .pat_status(pat_status), .flat_is_ones(flat_is_ones),
      .bit_err_stb(bit_err_stb), .status_irq(status_irq)
   );

   typedef struct {
      string      tag;
      bit         cs; logic [1:0] st;
      bit         ce; bit er;
      bit         ci; bit ir;
      bit         co; bit on;
   } exp_t;

   exp_t q[$];
   int   n_chk = 0, n_fail = 0;
   bit   done = 1'b0;

   // control shadows, applied at the falling edge by step()
   logic       c_en = 1'b0, c_alarm = 1'b0, c_m56 = 1'b0;
   logic [1:0] c_sel = 2'd0;
   logic [SLOT_W-1:0] c_slot = '0;
   logic [2:0] c_pos = 3'd0;
   logic [22:0] gs = 23'h0005A5;

   function automatic exp_t ex(string tag, bit cs, logic [1:0] st, bit ce, bit er,
                               bit ci, bit ir, bit co, bit on);
      exp_t e;
      e.tag = tag; e.cs = cs; e.st = st; e.ce = ce; e.er = er;
      e.ci = ci; e.ir = ir; e.co = co; e.on = on;
      return e;
   endfunction

   task automatic step(input bit v, input bit b, input exp_t e);
      @(negedge clk);
      mon_en = c_en; alarm_sim = c_alarm; poly_sel = c_sel; mode_56k = c_m56;
      rx_slot = c_slot; rx_bitpos = c_pos; rx_valid = v; rx_bit = b;
      @(posedge clk);
      q.push_back(e);
   endtask

   // bench reference generator: b[n] = b[n-a] ^ b[n-b]
   task automatic gen(output bit b);
      int a, c;
      case (c_sel)
         2'd0: begin a = 11; c = 9;  end
         2'd1: begin a = 15; c = 14; end
         2'd2: begin a = 20; c = 3;  end
         default: begin a = 23; c = 18; end
      endcase
      b  = gs[a-1] ^ gs[c-1];
      gs = {gs[21:0], b};
   endtask

   task automatic off_on();
      c_en = 1'b0;
      step(1'b0, 1'b0, ex("", 0, 2'b00, 0, 0, 0, 0, 0, 0));
      c_en = 1'b1;
   endtask

   // scoreboard monitor: results of a bit are due one edge later (R11)
   always @(negedge clk) begin
      if (q.size() > 0) begin
         exp_t e;
         e = q.pop_front();
         if (e.cs) begin
            n_chk++;
            if (pat_status !== e.st) begin
               n_fail++;
               $display("FAIL %s pat_status act=%b exp=%b", e.tag, pat_status, e.st);
            end
         end
         if (e.ce) begin
            n_chk++;
            if (bit_err_stb !== e.er) begin
               n_fail++;
               $display("FAIL %s bit_err_stb act=%b exp=%b", e.tag, bit_err_stb, e.er);
            end
         end
         if (e.ci) begin
            n_chk++;
            if (status_irq !== e.ir) begin
               n_fail++;
               $display("FAIL %s status_irq act=%b exp=%b", e.tag, status_irq, e.ir);
            end
         end
         if (e.co) begin
            n_chk++;
            if (flat_is_ones !== e.on) begin
               n_fail++;
               $display("FAIL %s flat_is_ones act=%b exp=%b", e.tag, flat_is_ones, e.on);
            end
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL R11 watchdog act=running exp=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      bit b;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state
      step(1'b0, 1'b0, ex("R1", 1, 2'b00, 1, 0, 1, 0, 1, 0));
      step(1'b0, 1'b0, ex("R1", 1, 2'b00, 1, 0, 1, 0, 1, 0));

      // R2, R6, R7: lock on true 2^11-1 at bit 22, one flip at 45 -> strobes 45, 54, 56
      c_en = 1'b1; c_sel = 2'd0;
      for (int i = 1; i <= 70; i++) begin
         gen(b);
         step(1'b1, b ^ (i == 45), ex("R2,R6,R7", 1, (i >= 22) ? 2'b01 : 2'b00,
              1, (i == 45 || i == 54 || i == 56), 1, (i == 22), 0, 0));
      end

      // R8: disabled slot 5 carries garbage, ignored
      c_slot = SLOT_W'(5);
      for (int i = 0; i < 20; i++)
         step(1'b1, i[0], ex("R8", 1, 2'b01, 1, 0, 1, 0, 0, 0));
      c_slot = '0;
      // R8: 56k mode, position 7 carries garbage, other positions continue
      c_m56 = 1'b1;
      for (int i = 0; i < 64; i++) begin
         c_pos = 3'(i % 8);
         if (c_pos == 3'd7) b = 1'b1; else gen(b);
         step(1'b1, b, ex("R8", 1, 2'b01, 1, 0, 1, 0, 0, 0));
      end
      c_m56 = 1'b0; c_pos = 3'd0;
      for (int i = 0; i < 20; i++) begin
         gen(b);
         step(1'b1, b, ex("R8", 1, 2'b01, 1, 0, 1, 0, 0, 0));
      end

      // R9: alarm simulation forces 00 and lock survives
      c_alarm = 1'b1;
      for (int i = 0; i < 3; i++) begin
         gen(b);
         step(1'b1, b, ex("R9,R6", 1, 2'b00, 1, 0, 1, (i == 0), 0, 0));
      end
      c_alarm = 1'b0;
      for (int i = 0; i < 5; i++) begin
         gen(b);
         step(1'b1, b, ex("R9,R6", 1, 2'b01, 1, 0, 1, (i == 0), 0, 0));
      end

      // R5: alternating stream produces errors every other bit -> unlock
      for (int i = 0; i < 100; i++)
         step(1'b1, i[0], (i == 99) ? ex("R5", 1, 2'b00, 1, 0, 0, 0, 0, 0)
                                    : ex("", 0, 2'b00, 0, 0, 0, 0, 0, 0));

      // R1: disabled -> quiet
      c_en = 1'b0;
      for (int i = 0; i < 5; i++) begin
         gen(b);
         step(1'b1, b, ex("R1", 1, 2'b00, 1, 0, 1, 0, 1, 0));
      end

      // R4, R6, R10: all zeros, flat at bit 12, true lock at 22 -> ones flag 0
      c_en = 1'b1;
      for (int i = 1; i <= 30; i++)
         step(1'b1, 1'b0, ex("R4,R6,R10", 1, (i >= 12) ? 2'b11 : 2'b00, 1, 0,
              1, (i >= 12), (i >= 23), 0));
      // R10: all ones, inverted lock at 22 -> ones flag 1
      off_on();
      for (int i = 1; i <= 30; i++)
         step(1'b1, 1'b1, ex("R4,R10", 1, (i >= 12) ? 2'b11 : 2'b00, 1, 0,
              1, (i >= 12), (i >= 23), (i >= 23)));

      // R4: 2^23-1 run length boundary 23 / 24
      c_sel = 2'd3;
      off_on();
      for (int i = 1; i <= 26; i++)
         step(1'b1, 1'b0, (i == 23 || i == 24)
              ? ex("R4", 1, (i == 24) ? 2'b11 : 2'b00, 0, 0, 0, 0, 0, 0)
              : ex("", 0, 2'b00, 0, 0, 0, 0, 0, 0));

      // R2: 2^23-1 true sequence locks at bit 46
      off_on();
      gs = 23'h2B3C5D;
      for (int i = 1; i <= 60; i++) begin
         gen(b);
         step(1'b1, b, ex("R2,R6", 1, (i >= 46) ? 2'b01 : 2'b00, 1, 0, 1, (i == 46), 0, 0));
      end

      // R3: inverted 2^11-1 locks as 10 at bit 22
      c_sel = 2'd0;
      off_on();
      gs = 23'h000713;
      for (int i = 1; i <= 30; i++) begin
         gen(b);
         step(1'b1, ~b, ex("R3", 1, (i >= 22) ? 2'b10 : 2'b00, 1, 0, 1, (i == 22), 0, 0));
      end

      repeat (2) @(negedge clk);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule